// File: doc/BRIEF.md
# Size-Aware Load/Store Byte Reorderer

This block sits between the data-cache access port and the register file and puts bytes into the right order for each load and store. The order depends on two things: the size of the item (byte, halfword or word) and a per-access little-endian flag. That flag comes from the byte-order attribute of the memory page being accessed. The native order is big endian. A cleared flag passes data straight through. A set flag reverses bytes within the item. Single bytes are never reordered.

On a load, the block selects the addressed byte or halfword lane from the 32-bit cache word and reverses it when needed. It then zero-extends or sign-extends the result into a register-ready value. On a store, it reverses the low bits of the source register when needed, replicates them across the word and produces a byte-enable mask for the addressed lanes. Accesses that are not naturally aligned raise a misalign flag and enable no bytes. A parameter selects either a purely combinational path or a single output register.

Top module: `ldst_swap`

## Requirements
- R1: Byte offset k (0..3) selects data bits [31-8k : 24-8k], so offset 0 is the most significant byte. Enable bit i of `store_be_o` covers store data bits [8i+7 : 8i], so offset k maps to enable bit 3-k. Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is invalid.
- R2: A byte load returns the addressed byte in bits [7:0] whatever the value of `le_i`.
- R3: A halfword load at offset o returns {byte o, byte o+1} when `le_i`=0 and {byte o+1, byte o} when `le_i`=1, in bits [15:0].
- R4: A word load returns the word unchanged when `le_i`=0 and with all four bytes reversed when `le_i`=1.
- R5: On byte and halfword loads, `sign_i`=1 copies the item's top bit into all higher bits and `sign_i`=0 clears them. Word loads ignore `sign_i`.
- R6: A byte store drives source bits [7:0] into all four lanes and enables only the addressed lane, whatever the value of `le_i`.
- R7: A halfword store drives source bits [15:0] into both halves, swapped when `le_i`=1, and enables the two lanes at the offset: 4'b1100 for offset 0 and 4'b0011 for offset 2.
- R8: A word store drives the source unchanged when `le_i`=0 and byte-reversed when `le_i`=1, with all four lanes enabled.
- R9: `misalign_o` is 1 exactly for a halfword at an odd offset, a word at a nonzero offset, or size code 3. When it is 1, `store_be_o` is 0.
- R10: When `store_i`=0 (load), `store_be_o` is 0.
- R11: With OUT_REG=1 (the default), every output reflects the inputs sampled at the previous rising clock edge. An active reset holds every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| store_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| offset_i | input | 2 | Byte offset within the word |
| le_i | input | 1 | Page byte order is little endian |
| sign_i | input | 1 | Sign-extend load value |
| data_i | input | 32 | Cache word (load) or source register (store) |
| load_data_o | output | 32 | Register-ready load value |
| store_data_o | output | 32 | Cache-ready store data |
| store_be_o | output | 4 | Store byte enables |
| misalign_o | output | 1 | Access is not naturally aligned |

## Verification
The block holds no state beyond the optional output stage, so a wrong lane select or a wrong swap decision shows up on the very next registered output. It appears as bytes in the wrong positions or a wrong extension fill in `load_data_o`, or as a wrong lane pattern in `store_be_o`. Distinct byte values in every lane make any swap of lanes visible. A stuck or skipped output register shows up as a value that arrives one cycle early or late, compared with the inputs that were changed on the falling edge between checks.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  function automatic logic [WORD_W-1:0] swap_word(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = d[8*(LANES-1-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/lsr_align_check.sv
module lsr_align_check
  import lsr_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             misalign_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = offset_i[0];
      SZ_WORD: misalign_o = |offset_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsr_load_path.sv
module lsr_load_path
  import lsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              le_i,
  input  logic              sign_i,
  output logic [WORD_W-1:0] value_o
);
  logic [7:0]  lane [LANES];
  logic [OFF_W-1:0] h_hi, h_lo;
  logic [15:0] half_v;
  logic [7:0]  byte_v;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = data_i[WORD_W-1-8*k -: 8];
  end

  assign h_hi   = {offset_i[OFF_W-1:1], 1'b0};
  assign h_lo   = {offset_i[OFF_W-1:1], 1'b1};
  assign byte_v = lane[offset_i];
  assign half_v = le_i ? {lane[h_lo], lane[h_hi]} : {lane[h_hi], lane[h_lo]};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(WORD_W-8){sign_i & byte_v[7]}}, byte_v};
      SZ_HALF: value_o = {{(WORD_W-16){sign_i & half_v[15]}}, half_v};
      default: value_o = le_i ? swap_word(data_i) : data_i;
    endcase
  end

  a_r5_byte_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_BYTE && !sign_i) |-> value_o[WORD_W-1:8] == '0);
  a_r5_half_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_HALF && sign_i) |-> value_o[WORD_W-1:16] == {(WORD_W-16){value_o[15]}});
  a_r2_byte_in_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == SZ_BYTE) |-> value_o[7:0] == data_i[WORD_W-1-8*offset_i -: 8]);
endmodule

// File: rtl/lsr_store_path.sv
module lsr_store_path
  import lsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              le_i,
  input  logic              store_i,
  input  logic              misalign_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  logic [15:0]      half_v;
  logic [LANES-1:0] be_raw;

  assign half_v = le_i ? {data_i[7:0], data_i[15:8]} : data_i[15:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        wdata_o = {LANES{data_i[7:0]}};
        be_raw  = LANES'(1) << (LANES-1-offset_i);
      end
      SZ_HALF: begin
        wdata_o = {(LANES/2){half_v}};
        be_raw  = offset_i[1] ? LANES'(4'b0011) : LANES'(4'b1100);
      end
      default: begin
        wdata_o = le_i ? swap_word(data_i) : data_i;
        be_raw  = '1;
      end
    endcase
  end

  assign be_o = (store_i && !misalign_i) ? be_raw : '0;

  a_r6_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == SZ_BYTE) |-> $countones(be_o) == 1);
  a_r7_half_two_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !misalign_i && size_i == SZ_HALF) |-> $countones(be_o) == 2);
  a_r8_word_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !misalign_i && size_i == SZ_WORD) |-> be_o == '1);
  a_r9_misalign_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_i |-> be_o == '0);
  a_r10_load_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |-> be_o == '0);
endmodule

// File: rtl/ldst_swap.sv
module ldst_swap
  import lsr_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        store_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  offset_i,
  input  logic        le_i,
  input  logic        sign_i,
  input  logic [31:0] data_i,
  output logic [31:0] load_data_o,
  output logic [31:0] store_data_o,
  output logic [3:0]  store_be_o,
  output logic        misalign_o
);
  logic [WORD_W-1:0] ld_c, st_c;
  logic [LANES-1:0]  be_c;
  logic              mis_c;

  lsr_align_check u_align (
    .size_i    (size_i),
    .offset_i  (offset_i),
    .misalign_o(mis_c)
  );

  lsr_load_path u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .size_i  (size_i),
    .offset_i(offset_i),
    .le_i    (le_i),
    .sign_i  (sign_i),
    .value_o (ld_c)
  );

  lsr_store_path u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .size_i    (size_i),
    .offset_i  (offset_i),
    .le_i      (le_i),
    .store_i   (store_i),
    .misalign_i(mis_c),
    .wdata_o   (st_c),
    .be_o      (be_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        load_data_o  <= '0;
        store_data_o <= '0;
        store_be_o   <= '0;
        misalign_o   <= 1'b0;
      end else begin
        load_data_o  <= ld_c;
        store_data_o <= st_c;
        store_be_o   <= be_c;
        misalign_o   <= mis_c;
      end
    end

    a_r11_one_cycle_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> store_be_o == $past(be_c));
    a_r11_one_cycle_ld: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> load_data_o == $past(ld_c));
  end else begin : g_comb
    assign load_data_o  = ld_c;
    assign store_data_o = st_c;
    assign store_be_o   = be_c;
    assign misalign_o   = mis_c;
  end
endmodule

// File: tb/sim_ldst_swap.sv
`timescale 1ns/1ps
module sim_ldst_swap;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        st = 1'b0, le = 1'b0, sg = 1'b0;
  logic [1:0]  sz = 2'd0, off = 2'd0;
  logic [31:0] din = '0;
  logic [31:0] ld_o, st_o;
  logic [3:0]  be_o;
  logic        mis_o;
  int total = 0, bad = 0;

  localparam logic [31:0] DW = 32'hA1B2C3D4;
  localparam logic [31:0] SR = 32'h11223344;

  always #2 clk = ~clk;

  ldst_swap u0 (
    .clk_i(clk), .rst_ni(rst_n), .store_i(st), .size_i(sz), .offset_i(off),
    .le_i(le), .sign_i(sg), .data_i(din),
    .load_data_o(ld_o), .store_data_o(st_o), .store_be_o(be_o), .misalign_o(mis_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, result visible one rising edge later
  task automatic apply(input logic s, input logic [1:0] z, input logic [1:0] o,
                       input logic l, input logic g, input logic [31:0] d);
    @(negedge clk);
    st = s; sz = z; off = o; le = l; sg = g; din = d;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R11 reset ld", ld_o, 32'h0);
    chk("R11 reset be", {28'h0, be_o}, 32'h0);
    chk("R11 reset mis", {31'h0, mis_o}, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_byte_load;
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < 2; l++) begin
        apply(1'b0, 2'd0, 2'(k), 1'(l), 1'b0, DW);
        chk("R2 byte load", ld_o, {24'h0, DW[31-8*k -: 8]});
        chk("R10 load be", {28'h0, be_o}, 32'h0);
      end
    end
  endtask

  task automatic t_half_load;
    apply(1'b0, 2'd1, 2'd0, 1'b0, 1'b0, DW); chk("R3 half be off0", ld_o, 32'h0000A1B2);
    apply(1'b0, 2'd1, 2'd2, 1'b0, 1'b0, DW); chk("R3 half be off2", ld_o, 32'h0000C3D4);
    apply(1'b0, 2'd1, 2'd0, 1'b1, 1'b0, DW); chk("R3 half le off0", ld_o, 32'h0000B2A1);
    apply(1'b0, 2'd1, 2'd2, 1'b1, 1'b0, DW); chk("R3 half le off2", ld_o, 32'h0000D4C3);
    chk("R10 half load be", {28'h0, be_o}, 32'h0);
  endtask

  task automatic t_word_load;
    apply(1'b0, 2'd2, 2'd0, 1'b0, 1'b0, DW); chk("R4 word be", ld_o, 32'hA1B2C3D4);
    apply(1'b0, 2'd2, 2'd0, 1'b1, 1'b0, DW); chk("R4 word le", ld_o, 32'hD4C3B2A1);
    chk("R9 aligned word", {31'h0, mis_o}, 32'h0);
  endtask

  task automatic t_extend;
    apply(1'b0, 2'd0, 2'd0, 1'b0, 1'b1, DW); chk("R5 byte sext neg", ld_o, 32'hFFFFFFA1);
    apply(1'b0, 2'd0, 2'd3, 1'b1, 1'b1, SR); chk("R5 byte sext pos", ld_o, 32'h00000044);
    apply(1'b0, 2'd1, 2'd0, 1'b0, 1'b1, DW); chk("R5 half sext be", ld_o, 32'hFFFFA1B2);
    apply(1'b0, 2'd1, 2'd0, 1'b1, 1'b1, DW); chk("R5 half sext le", ld_o, 32'hFFFFB2A1);
    apply(1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 32'h00007F80); chk("R5 half sext pos", ld_o, 32'h00007F80);
    apply(1'b0, 2'd2, 2'd0, 1'b1, 1'b1, DW); chk("R5 word ignores sign", ld_o, 32'hD4C3B2A1);
  endtask

  task automatic t_byte_store;
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < 2; l++) begin
        apply(1'b1, 2'd0, 2'(k), 1'(l), 1'b0, SR);
        chk("R6 byte store data", st_o, 32'h44444444);
        chk("R1 R6 byte store be", {28'h0, be_o}, 32'(4'b1000 >> k));
      end
    end
  endtask

  task automatic t_half_store;
    apply(1'b1, 2'd1, 2'd0, 1'b0, 1'b0, SR);
    chk("R7 half store be data", st_o, 32'h33443344); chk("R7 be off0", {28'h0, be_o}, 32'hC);
    apply(1'b1, 2'd1, 2'd2, 1'b1, 1'b0, SR);
    chk("R7 half store le data", st_o, 32'h44334433); chk("R7 be off2", {28'h0, be_o}, 32'h3);
  endtask

  task automatic t_word_store;
    apply(1'b1, 2'd2, 2'd0, 1'b0, 1'b0, SR);
    chk("R8 word store be", st_o, 32'h11223344); chk("R8 be all", {28'h0, be_o}, 32'hF);
    apply(1'b1, 2'd2, 2'd0, 1'b1, 1'b0, SR);
    chk("R8 word store le", st_o, 32'h44332211); chk("R8 be all le", {28'h0, be_o}, 32'hF);
  endtask

  task automatic t_misalign;
    for (int o = 1; o < 4; o += 2) begin
      apply(1'b1, 2'd1, 2'(o), 1'b0, 1'b0, SR);
      chk("R9 half odd mis", {31'h0, mis_o}, 32'h1);
      chk("R9 half odd be", {28'h0, be_o}, 32'h0);
    end
    for (int o = 1; o < 4; o++) begin
      apply(1'b1, 2'd2, 2'(o), 1'b1, 1'b0, SR);
      chk("R9 word off mis", {31'h0, mis_o}, 32'h1);
      chk("R9 word off be", {28'h0, be_o}, 32'h0);
    end
    apply(1'b1, 2'd3, 2'd0, 1'b0, 1'b0, SR);
    chk("R9 bad size mis", {31'h0, mis_o}, 32'h1);
    chk("R9 bad size be", {28'h0, be_o}, 32'h0);
    apply(1'b0, 2'd1, 2'd2, 1'b0, 1'b0, SR);
    chk("R9 aligned half", {31'h0, mis_o}, 32'h0);
  endtask

  task automatic t_latency;
    apply(1'b0, 2'd2, 2'd0, 1'b0, 1'b0, DW);
    @(negedge clk);
    le = 1'b1;
    #1 chk("R11 holds until edge", ld_o, 32'hA1B2C3D4);
    @(posedge clk); #1;
    chk("R11 updates after edge", ld_o, 32'hD4C3B2A1);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R11 async reset", ld_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_byte_load;
        t_half_load;
        t_word_load;
        t_extend;
        t_byte_store;
        t_half_store;
        t_word_store;
        t_misalign;
        t_latency;
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule